// File: doc/BRIEF.md
# Waitable Pixel Serializer

This block turns one data word per frame into a serial bit stream. It is paced by a single-cycle tick input, which stands in for a pixel clock, and a run control that gates that tick. A pace word sets two things: how many ticks each output bit lasts, and how many ticks the whole frame lasts. Bits leave least-significant first. Once the word runs out of bits, its final bit stays on the line until the frame ends.

The frame end is the only point at which anything is reloaded. At that point the frame and bit timers reload from the pace word, and the next data word is captured from the host's data bus. The capture happens whether or not a host is waiting. A host synchronises by raising a valid request and waiting for ready. Ready is given only on a reload cycle, so waiting cannot shorten or restart a frame.

After reset the frame timer holds the largest count it can take. The first reload therefore comes 4096 enabled ticks after reset, using the default parameters.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is held, `ser_o` is 1 and `host_ready_o` is 0. The first reload happens on the 4096th tick with run high after reset is released. Until that reload, `ser_o` stays 1.
- R2: A frame-length field `pace_i[11:0]` of 0 gives a frame of 4096 enabled ticks.
- R3: A frame lasts exactly the frame-length value that was sampled at the reload which started it. A change to `pace_i` in the middle of a frame has no effect on that frame's length or its bit period.
- R4: On the reload tick, `data_i` is captured whatever the state of `host_valid_i`. From the next cycle, `ser_o` shows bit 0 of the captured word, and later changes to `data_i` do not affect the frame.
- R5: With a bit period P (`pace_i[19:12]`), bit k of the word appears k·P enabled ticks after the reload. After bit 31, the line holds bit 31 until the frame ends.
- R6: `host_ready_o` is high only in a cycle where `host_valid_i`, `tick_i` and `run_i` are all high and the frame timer is on its last tick. That is the cycle whose clock edge performs the reload.
- R7: A tick while `run_i` is low, or a cycle with `tick_i` low, changes neither the timers nor `ser_o`. Counting resumes from where it stopped.
- R8: A bit-period field of 0 is taken as one tick per bit.
- R9: With a frame length of 1, a reload happens on every enabled tick, and each reload picks up the pace and data present at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle pixel-clock enable |
| run_i | input | 1 | Enable; when low the timers are frozen |
| pace_i | input | 20 | [19:12] ticks per bit, [11:0] ticks per frame |
| data_i | input | 32 | Word captured at each reload |
| host_valid_i | input | 1 | Host is waiting for the next reload |
| host_ready_o | output | 1 | Reload is happening this cycle for a waiting host |
| ser_o | output | 1 | Serial output |

## Verification
`host_ready_o` is combinational. It is due in the cycle before the reload edge, so it is sampled at the falling edge of that cycle. `ser_o` comes from registers: bit 0 is due in the cycle after the reload edge, and bit k is due k·P enabled ticks later. The scoreboard labels every expected value with an absolute cycle number, counted from the release of reset. The monitor compares each value at the falling edge of that exact cycle, and an item that is still pending after its cycle has passed counts as a failure. Pauses are inserted at known cycles, and the cycle numbers that follow them are shifted by the length of the pause.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   localparam int unsigned PXS_PER_W  = 8;
   localparam int unsigned PXS_LEN_W  = 12;
   localparam int unsigned PXS_WORD_W = 32;

   typedef enum logic {
      PXS_ORDER_LSB = 1'b0,
      PXS_ORDER_MSB = 1'b1
   } pxs_order_e;
endpackage

// File: rtl/pxs_frame_timer.sv
module pxs_frame_timer #(
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             reload_o,
   output logic [LEN_W:0]   cnt_o
);
   localparam logic [LEN_W:0] FULL = (LEN_W+1)'(1) << LEN_W;
   localparam logic [LEN_W:0] ONE  = (LEN_W+1)'(1);

   logic [LEN_W:0] cnt_q;
   logic [LEN_W:0] next_len;

   assign next_len = (len_i == '0) ? FULL : {1'b0, len_i};
   assign reload_o = step_i && (cnt_q == ONE);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= FULL;
      end else if (reload_o) begin
         cnt_q <= next_len;
      end else if (step_i) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/pxs_pixel_timer.sv
module pxs_pixel_timer #(
   parameter int unsigned PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             reload_i,
   input  logic [PER_W-1:0] per_i,
   output logic             adv_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] eff_per;

   assign eff_per = (per_i == '0) ? ONE : per_i;
   assign adv_o   = step_i && !reload_i && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= ONE;
         cnt_q <= ONE;
      end else if (reload_i) begin
         per_q <= eff_per;
         cnt_q <= eff_per;
      end else if (adv_o) begin
         cnt_q <= per_q;
      end else if (step_i) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter
   import pxs_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter pxs_order_e  ORDER  = PXS_ORDER_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_i,
   input  logic              adv_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              ser_o
);
   localparam int unsigned       IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0]  LAST  = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '1;
         idx_q  <= '0;
      end else if (reload_i) begin
         word_q <= data_i;
         idx_q  <= '0;
      end else if (adv_i && (idx_q != LAST)) begin
         idx_q  <= idx_q + IDX_W'(1);
      end
   end

   generate
      if (ORDER == PXS_ORDER_LSB) begin : g_lsb
         assign ser_o = word_q[idx_q];
      end else begin : g_msb
         assign ser_o = word_q[LAST - idx_q];
      end
   endgenerate
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
   import pxs_pkg::*;
#(
   parameter int unsigned PER_W  = PXS_PER_W,
   parameter int unsigned LEN_W  = PXS_LEN_W,
   parameter int unsigned WORD_W = PXS_WORD_W,
   parameter pxs_order_e  ORDER  = PXS_ORDER_LSB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    run_i,
   input  logic [PER_W+LEN_W-1:0]  pace_i,
   input  logic [WORD_W-1:0]       data_i,
   input  logic                    host_valid_i,
   output logic                    host_ready_o,
   output logic                    ser_o
);
   localparam int unsigned PACE_W = PER_W + LEN_W;

   generate
      if (PER_W < 1 || PER_W > 16) begin : g_bad_per
         $error("pixel_serializer: PER_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
         $error("pixel_serializer: LEN_W out of range");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("pixel_serializer: WORD_W must be at least 2");
      end
   endgenerate

   logic             step;
   logic             frm_reload;
   logic [LEN_W:0]   frm_cnt;
   logic             bit_adv;
   logic [LEN_W-1:0] len_field;
   logic [PER_W-1:0] per_field;

   assign step      = tick_i && run_i;
   assign len_field = pace_i[LEN_W-1:0];
   assign per_field = pace_i[PACE_W-1:LEN_W];

   pxs_frame_timer #(.LEN_W(LEN_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .len_i    (len_field),
      .reload_o (frm_reload),
      .cnt_o    (frm_cnt)
   );

   pxs_pixel_timer #(.PER_W(PER_W)) u_pixel (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .reload_i (frm_reload),
      .per_i    (per_field),
      .adv_o    (bit_adv)
   );

   pxs_shifter #(.WORD_W(WORD_W), .ORDER(ORDER)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (frm_reload),
      .adv_i    (bit_adv),
      .data_i   (data_i),
      .ser_o    (ser_o)
   );

   assign host_ready_o = frm_reload && host_valid_i;
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
   parameter int unsigned LEN_W = 12,
   parameter bit          LSB   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             run_i,
   input logic [LEN_W-1:0] pace_len,
   input logic             data_lsb,
   input logic             host_valid_i,
   input logic             host_ready_o,
   input logic             ser_o,
   input logic [LEN_W:0]   frm_cnt,
   input logic             reload
);
   localparam logic [LEN_W:0] FULL = (LEN_W+1)'(1) << LEN_W;

   a_r6_ready_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready_o |-> (host_valid_i && tick_i && run_i));

   a_r7_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && run_i) |=> ($stable(ser_o) && $stable(frm_cnt)));

   a_r2_frame_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      frm_cnt != '0);

   a_r3_reload_length: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> frm_cnt == (($past(pace_len) == '0) ? FULL : {1'b0, $past(pace_len)}));

   a_r4_capture_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && LSB) |=> ser_o == $past(data_lsb));
endmodule

bind pixel_serializer pixel_serializer_chk #(
   .LEN_W (LEN_W),
   .LSB   (ORDER == pxs_pkg::PXS_ORDER_LSB)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .run_i        (run_i),
   .pace_len     (pace_i[LEN_W-1:0]),
   .data_lsb     (data_i[0]),
   .host_valid_i (host_valid_i),
   .host_ready_o (host_ready_o),
   .ser_o        (ser_o),
   .frm_cnt      (frm_cnt),
   .reload       (frm_reload)
);

// File: tb/pixel_serializer_tb.sv
module pixel_serializer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b1;
   logic        run_i = 1'b1;
   logic [19:0] pace_i;
   logic [31:0] data_i;
   logic        host_valid_i = 1'b1;
   logic        host_ready_o;
   logic        ser_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   localparam logic [31:0] WA = 32'hA5C3_0F96;
   localparam logic [31:0] WB = 32'h1234_567F;
   localparam logic [31:0] WC = 32'h8000_0001;
   localparam logic [31:0] WD = 32'h0000_00F0;
   localparam logic [31:0] WE = 32'h0000_001A;
   localparam logic [31:0] WF = 32'h0000_0001;
   localparam logic [31:0] WG = 32'h0000_0002;

   typedef struct {
      int at;
      bit chk_out;
      bit out;
      bit chk_rdy;
      bit rdy;
      int req;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   pixel_serializer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .run_i        (run_i),
      .pace_i       (pace_i),
      .data_i       (data_i),
      .host_valid_i (host_valid_i),
      .host_ready_o (host_ready_o),
      .ser_o        (ser_o)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [19:0] mk(input int per, input int len);
      return {per[7:0], len[11:0]};
   endfunction

   task automatic push(input int at, input bit co, input bit o, input bit cr, input bit r, input int req);
      exp_t e;
      e.at = at; e.chk_out = co; e.out = o; e.chk_rdy = cr; e.rdy = r; e.req = req;
      sb.push_back(e);
   endtask

   task automatic at_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   // monitor: pops each expected item at the falling edge of its cycle
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
               exp_t e;
               e = sb.pop_front();
               if (e.at < cyc) begin
                  n_chk++; n_fail++;
                  $display("FAIL R%0d: item for cycle %0d missed (now %0d)", e.req, e.at, cyc);
               end else begin
                  if (e.chk_out) begin
                     n_chk++;
                     if (ser_o !== e.out) begin
                        n_fail++;
                        $display("FAIL R%0d: cycle %0d ser_o=%b expected %b", e.req, cyc, ser_o, e.out);
                     end
                  end
                  if (e.chk_rdy) begin
                     n_chk++;
                     if (host_ready_o !== e.rdy) begin
                        n_fail++;
                        $display("FAIL R%0d: cycle %0d host_ready_o=%b expected %b", e.req, cyc, host_ready_o, e.rdy);
                     end
                  end
               end
            end
         end
      end
   end

   // driver
   initial begin
      pace_i = mk(2, 10);
      data_i = WA;
      // R1: values expected while reset is held and before the first reload
      push(4094, 1, 1'b1, 1, 1'b0, 1);
      push(4095, 1, 1'b1, 1, 1'b1, 1);
      push(4096, 1, WA[0], 1, 1'b0, 4);        // R4
      push(4097, 1, WA[0], 0, 1'b0, 5);        // R5 held for P=2
      push(4098, 1, WA[1], 0, 1'b0, 5);
      push(4100, 1, WA[2], 0, 1'b0, 5);
      push(4102, 1, WA[3], 0, 1'b0, 5);
      push(4103, 0, 1'b0, 1, 1'b0, 3);         // R3 mid-frame pace change ignored
      push(4104, 1, WA[4], 0, 1'b0, 5);
      push(4105, 0, 1'b0, 1, 1'b1, 3);
      push(4106, 1, WB[0], 0, 1'b0, 4);
      push(4109, 1, WB[1], 0, 1'b0, 5);
      push(4111, 0, 1'b0, 1, 1'b1, 3);
      push(4112, 1, WC[0], 0, 1'b0, 4);
      push(4117, 1, WC[5], 0, 1'b0, 5);
      push(4142, 1, WC[30], 0, 1'b0, 5);
      push(4143, 1, WC[31], 0, 1'b0, 5);
      push(4147, 1, WC[31], 0, 1'b0, 5);       // R5 last bit held
      push(4151, 1, WC[31], 1, 1'b0, 6);       // R6 no ready without valid
      push(4152, 1, WD[0], 0, 1'b0, 8);        // R8 period 0 as 1
      push(4156, 1, WD[4], 0, 1'b0, 8);
      push(4160, 1, WD[8], 0, 1'b0, 8);
      push(8246, 0, 1'b0, 1, 1'b0, 2);         // R2 frame 0 as 4096
      push(8247, 0, 1'b0, 1, 1'b1, 2);
      push(8248, 1, WE[0], 0, 1'b0, 4);
      push(8249, 1, WE[1], 0, 1'b0, 5);
      push(8252, 1, WE[1], 1, 1'b0, 7);        // R7 run low
      push(8257, 1, WE[1], 0, 1'b0, 7);        // R7 tick low
      push(8261, 1, WE[3], 0, 1'b0, 7);
      push(8262, 0, 1'b0, 1, 1'b1, 7);
      push(8263, 1, WF[0], 1, 1'b1, 9);        // R9 frame of one tick
      push(8264, 1, WF[0], 1, 1'b1, 9);
      push(8265, 1, WG[0], 1, 1'b0, 9);
      push(8266, 1, WG[1], 1, 1'b0, 9);
      push(8267, 0, 1'b0, 1, 1'b1, 9);

      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (ser_o !== 1'b1 || host_ready_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: in reset ser_o=%b ready=%b expected 1 0", ser_o, host_ready_o);
      end
      rst_n = 1'b1;

      at_cyc(4097); data_i = WB;
      at_cyc(4098); pace_i = mk(3, 6);
      at_cyc(4107); pace_i = mk(1, 40); data_i = WC;
      at_cyc(4140); host_valid_i = 1'b0; pace_i = mk(0, 0); data_i = WD;
      at_cyc(4200); host_valid_i = 1'b1; pace_i = mk(1, 5); data_i = WE;
      at_cyc(8249); run_i = 1'b0;
      at_cyc(8254); run_i = 1'b1; tick_i = 1'b0;
      at_cyc(8255); pace_i = mk(1, 1); data_i = WF;
      at_cyc(8259); tick_i = 1'b1;
      at_cyc(8264); pace_i = mk(1, 3); data_i = WG;
      at_cyc(8272);
      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R3: %0d expected items never compared (actual 0 pending expected)", sb.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1: watchdog expired at cycle %0d, expected end by 8272", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule